// File: doc/BRIEF.md
# USB Device Interrupt Flag Register

This block holds the interrupt status seen by software in a USB device-function controller. One 8-bit word combines two kinds of bit. Three sticky event flags are raised by single-cycle pulses from the USB protocol core: a bus reset was seen, the host sent an IN token to the transmit endpoint while that endpoint had nothing to send, and a setup command that software must decode has been received and acknowledged. Two live status bits follow FIFO state: the receive endpoint FIFO holds a complete packet, and at least one of the two transmit buffers of the transmit endpoint can take data.

Software reads the flag word and clears sticky flags with a mask-style write. A written 0 clears the flag in that position and a written 1 leaves it unchanged, so one write can acknowledge exactly the events that were handled and cannot disturb the others. The live bits and the three reserved low bits ignore writes. A companion 8-bit enable register selects which bits may raise the single level-sensitive interrupt request. The interrupt request is registered. A separate output tells the packet engine that the transmit endpoint must keep answering NACK while its transfer-request flag is set.

Top module: `usb_irq_flags`

## Requirements
- R1: While rst_n is low at a clock edge, the flag word becomes 0x10, the enable word becomes 0x00 and irq_o becomes 0.
- R2: A pulse on evt_bus_reset_i, evt_tx_request_i or evt_setup_done_i sets flag bit 7, 5 or 3 respectively at that clock edge. The bit stays 1 after the pulse ends.
- R3: A flag write clears each sticky flag (bits 7, 5, 3) whose written bit is 0. A sticky flag whose written bit is 1 keeps its value.
- R4: When a set pulse and a clearing write reach the same sticky flag at the same edge, the flag ends up 1.
- R5: Flag bit 6 shows the value rx_fifo_full_i had at the previous clock edge. Flag writes do not change it.
- R6: Flag bit 4 shows the OR of the two tx_buf_free_i bits as they were at the previous clock edge. Flag writes do not change it.
- R7: Flag bits 2 to 0 always read 0, whatever is written to them.
- R8: An enable write stores all 8 bits of cpu_wdata_i, and en_rdata_o returns them from the next cycle on.
- R9: irq_o is 1 one cycle after any flag bit and the matching enable bit are both 1, and is 0 one cycle after no such pair exists.
- R10: nack_required_o is 1 exactly while flag bit 5 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_bus_reset_i | input | 1 | Pulse: bus reset detected |
| evt_tx_request_i | input | 1 | Pulse: IN token arrived at the transmit endpoint with no data ready |
| evt_setup_done_i | input | 1 | Pulse: setup command received and acknowledged |
| rx_fifo_full_i | input | 1 | Live: receive FIFO holds valid data |
| tx_buf_free_i | input | 2 | Live: per transmit buffer, 1 when it can accept data |
| cpu_wr_flag_i | input | 1 | Write strobe for the flag word (0 clears, 1 keeps) |
| cpu_wr_en_i | input | 1 | Write strobe for the enable word |
| cpu_wdata_i | input | 8 | Write data |
| flag_rdata_o | output | 8 | Flag word |
| en_rdata_o | output | 8 | Enable word |
| irq_o | output | 1 | Registered level interrupt request |
| nack_required_o | output | 1 | Transmit endpoint must answer NACK |

## Verification
The hardest case to reach is a set pulse and a clearing write that hit the same flag at the same clock edge, because the event side and the CPU side have no relation in normal use. The bench drives both in one cycle and checks that the flag survives. In the same way it runs a write of all zeros while a live bit is high, which shows that the status bits cannot be cleared. It also steps the two transmit-buffer inputs through every combination, so the "either buffer free" OR is checked in full rather than only in its all-ones reset state.

// File: rtl/usb_irq_pkg.sv
// Package: usb_irq_pkg
// Shared layout of the interrupt flag word. The bit positions are fixed
// because software decodes them; everything else is derived here.
package usb_irq_pkg;
    localparam int unsigned FLAG_W   = 8;
    localparam int unsigned EVT_CNT  = 3;
    localparam int unsigned TXBUF_N  = 2;

    // Sticky event flag positions: bus reset, transmit request, setup done
    localparam int unsigned POS_BUS_RESET = 7;
    localparam int unsigned POS_RX_FULL   = 6;
    localparam int unsigned POS_TX_REQ    = 5;
    localparam int unsigned POS_TX_FREE   = 4;
    localparam int unsigned POS_SETUP     = 3;
    localparam int unsigned RSVD_HI       = 2;

    localparam int unsigned EVT_POS [EVT_CNT] = '{POS_BUS_RESET, POS_TX_REQ, POS_SETUP};

    // Power-on value of the flag word: only the transmit-free bit is 1
    localparam logic [FLAG_W-1:0] FLAG_RST = FLAG_W'(1) << POS_TX_FREE;
    localparam logic [FLAG_W-1:0] EN_RST   = '0;
endpackage

// File: rtl/usb_irq_sticky_bit.sv
// Module: usb_irq_sticky_bit
// One software-clearable event flag. A set pulse raises it; a clear
// request drops it; a set in the same cycle as a clear wins.
// Assumes set_i is a synchronous pulse from the protocol core.
module usb_irq_sticky_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    logic q_r;

    // Flag storage with set-over-clear priority
    always_ff @(posedge clk) begin
        if (!rst_n)       q_r <= 1'b0;
        else if (set_i)   q_r <= 1'b1;
        else if (clr_i)   q_r <= 1'b0;
    end

    assign q_o = q_r;

    assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o);
    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q_o);
    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/usb_irq_live_bit.sv
// Module: usb_irq_live_bit
// Registered copy of a FIFO status condition, formed as the OR of SRC_N
// source lines. It is read-only to software and has a fixed reset value.
// Assumes the sources are synchronous to clk.
module usb_irq_live_bit #(
    parameter int unsigned SRC_N   = 1,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] src_i,
    output logic             q_o
);
    logic q_r;

    // Capture the OR of the sources each cycle
    always_ff @(posedge clk) begin
        if (!rst_n) q_r <= RST_VAL;
        else        q_r <= |src_i;
    end

    assign q_o = q_r;

    assert_live_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i == '0) |=> !q_o);
endmodule

// File: rtl/usb_irq_mask_gen.sv
// Module: usb_irq_mask_gen
// Enable register and registered interrupt request. The request is high
// when any flag bit is 1 and its enable bit is also 1.
// Assumes flag_i comes from registers in the same clock domain.
module usb_irq_mask_gen #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic [W-1:0] flag_i,
    output logic [W-1:0] en_o,
    output logic         irq_o
);
    logic [W-1:0] en_r;
    logic         irq_r;

    // Enable register: full-width write
    always_ff @(posedge clk) begin
        if (!rst_n)    en_r <= usb_irq_pkg::EN_RST;
        else if (wr_i) en_r <= wdata_i;
    end

    // Registered level request from the masked flags
    always_ff @(posedge clk) begin
        if (!rst_n) irq_r <= 1'b0;
        else        irq_r <= |(flag_i & en_r);
    end

    assign en_o  = en_r;
    assign irq_o = irq_r;

    assert_en_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (en_o == $past(wdata_i)));
    assert_irq_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == |($past(flag_i) & $past(en_o))));
endmodule

// File: rtl/usb_irq_flags.sv
// Module: usb_irq_flags (top)
// Interrupt flag word of a USB device-function controller: three sticky
// event flags, two live FIFO status bits and three reserved zero bits.
// Software clears sticky flags by writing 0 to them and 1 elsewhere. An
// enable register masks the flags into one registered level interrupt.
// Assumes all inputs are synchronous to clk.
module usb_irq_flags
    import usb_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                evt_bus_reset_i,
    input  logic                evt_tx_request_i,
    input  logic                evt_setup_done_i,
    input  logic                rx_fifo_full_i,
    input  logic [TXBUF_N-1:0]  tx_buf_free_i,
    input  logic                cpu_wr_flag_i,
    input  logic                cpu_wr_en_i,
    input  logic [FLAG_W-1:0]   cpu_wdata_i,
    output logic [FLAG_W-1:0]   flag_rdata_o,
    output logic [FLAG_W-1:0]   en_rdata_o,
    output logic                irq_o,
    output logic                nack_required_o
);
    logic [EVT_CNT-1:0] evt_set;
    logic [EVT_CNT-1:0] evt_clr;
    logic [EVT_CNT-1:0] evt_q;
    logic               rx_full_q;
    logic               tx_free_q;
    logic [FLAG_W-1:0]  flag_word;

    // Event pulses in the order of EVT_POS
    assign evt_set[0] = evt_bus_reset_i;
    assign evt_set[1] = evt_tx_request_i;
    assign evt_set[2] = evt_setup_done_i;

    // One sticky cell per event; a written 0 at its position clears it
    for (genvar g = 0; g < EVT_CNT; g++) begin : g_evt
        assign evt_clr[g] = cpu_wr_flag_i && !cpu_wdata_i[EVT_POS[g]];
        usb_irq_sticky_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (evt_set[g]),
            .clr_i (evt_clr[g]),
            .q_o   (evt_q[g])
        );
    end

    usb_irq_live_bit #(.SRC_N(1), .RST_VAL(1'b0)) u_rx_full (
        .clk   (clk),
        .rst_n (rst_n),
        .src_i (rx_fifo_full_i),
        .q_o   (rx_full_q)
    );

    usb_irq_live_bit #(.SRC_N(TXBUF_N), .RST_VAL(FLAG_RST[POS_TX_FREE])) u_tx_free (
        .clk   (clk),
        .rst_n (rst_n),
        .src_i (tx_buf_free_i),
        .q_o   (tx_free_q)
    );

    // Assemble the readable flag word; reserved bits stay 0
    always_comb begin
        flag_word = '0;
        for (int i = 0; i < EVT_CNT; i++) flag_word[EVT_POS[i]] = evt_q[i];
        flag_word[POS_RX_FULL] = rx_full_q;
        flag_word[POS_TX_FREE] = tx_free_q;
    end

    usb_irq_mask_gen #(.W(FLAG_W)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (cpu_wr_en_i),
        .wdata_i (cpu_wdata_i),
        .flag_i  (flag_word),
        .en_o    (en_rdata_o),
        .irq_o   (irq_o)
    );

    assign flag_rdata_o    = flag_word;
    assign nack_required_o = evt_q[1];

    assert_reset_value_R1: assert property (@(posedge clk)
        !rst_n |=> (flag_rdata_o == FLAG_RST && en_rdata_o == EN_RST && !irq_o));
    assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flag_rdata_o[RSVD_HI:0] == '0);
    assert_rx_mirror_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (flag_rdata_o[POS_RX_FULL] == $past(rx_fifo_full_i)));
    assert_tx_free_or_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (flag_rdata_o[POS_TX_FREE] == |$past(tx_buf_free_i)));
    assert_nack_on_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        evt_tx_request_i |=> nack_required_o);
    assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        evt_bus_reset_i |=> flag_rdata_o[POS_BUS_RESET]);
endmodule

// File: tb/usb_irq_flags_tb_top.sv
module usb_irq_flags_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       evt_bus_reset_i = 1'b0;
    logic       evt_tx_request_i = 1'b0;
    logic       evt_setup_done_i = 1'b0;
    logic       rx_fifo_full_i = 1'b0;
    logic [1:0] tx_buf_free_i = 2'b11;
    logic       cpu_wr_flag_i = 1'b0;
    logic       cpu_wr_en_i = 1'b0;
    logic [7:0] cpu_wdata_i = 8'h00;
    logic [7:0] flag_rdata_o;
    logic [7:0] en_rdata_o;
    logic       irq_o;
    logic       nack_required_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        string      req;
        logic [7:0] flags;
        logic [7:0] en;
        logic       irq;
        logic       nack;
    } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;   // 125 MHz

    usb_irq_flags dut_i (
        .clk(clk), .rst_n(rst_n),
        .evt_bus_reset_i(evt_bus_reset_i), .evt_tx_request_i(evt_tx_request_i),
        .evt_setup_done_i(evt_setup_done_i), .rx_fifo_full_i(rx_fifo_full_i),
        .tx_buf_free_i(tx_buf_free_i), .cpu_wr_flag_i(cpu_wr_flag_i),
        .cpu_wr_en_i(cpu_wr_en_i), .cpu_wdata_i(cpu_wdata_i),
        .flag_rdata_o(flag_rdata_o), .en_rdata_o(en_rdata_o),
        .irq_o(irq_o), .nack_required_o(nack_required_o)
    );

    // Driver side: queue the expectation for the present sample point
    task automatic expect_now(string req, logic [7:0] f, logic [7:0] e, logic i, logic n);
        exp_t it;
        it.req = req; it.flags = f; it.en = e; it.irq = i; it.nack = n;
        exp_q.push_back(it);
        #1;
    endtask

    // Advance one clock; inputs change and samples are taken at negedge
    task automatic tick();
        @(negedge clk);
        evt_bus_reset_i = 0; evt_tx_request_i = 0; evt_setup_done_i = 0;
        cpu_wr_flag_i = 0; cpu_wr_en_i = 0;
    endtask

    task automatic wr_flag(logic [7:0] d);
        cpu_wr_flag_i = 1; cpu_wdata_i = d; tick();
    endtask

    task automatic wr_en(logic [7:0] d);
        cpu_wr_en_i = 1; cpu_wdata_i = d; tick();
    endtask

    // Monitor side: pop and compare against the DUT outputs
    initial begin
        forever begin
            exp_t it;
            wait (exp_q.size() != 0);
            it = exp_q.pop_front();
            n_checks++;
            if (flag_rdata_o !== it.flags || en_rdata_o !== it.en ||
                irq_o !== it.irq || nack_required_o !== it.nack) begin
                n_fail++;
                $display("FAIL %s: flags=%h en=%h irq=%b nack=%b expected flags=%h en=%h irq=%b nack=%b",
                    it.req, flag_rdata_o, en_rdata_o, irq_o, nack_required_o,
                    it.flags, it.en, it.irq, it.nack);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        expect_now("R1", 8'h10, 8'h00, 0, 0);
        rst_n = 1; tick();
        expect_now("R1", 8'h10, 8'h00, 0, 0);

        // R2: bus reset pulse sets bit 7 and stays; enable 0 keeps irq low (R9)
        evt_bus_reset_i = 1; tick();
        expect_now("R2", 8'h90, 8'h00, 0, 0);
        tick(); tick();
        expect_now("R2", 8'h90, 8'h00, 0, 0);

        // R8/R9: enable bit 7 -> irq one cycle later
        wr_en(8'h80);
        expect_now("R8", 8'h90, 8'h80, 0, 0);
        tick();
        expect_now("R9", 8'h90, 8'h80, 1, 0);

        // R3: write 0 to bit 7 clears it; irq drops one cycle later (R9)
        wr_flag(8'h7F);
        expect_now("R3", 8'h10, 8'h80, 1, 0);
        tick();
        expect_now("R9", 8'h10, 8'h80, 0, 0);

        // R2/R10: transfer request and setup flags
        evt_tx_request_i = 1; tick();
        expect_now("R10", 8'h30, 8'h80, 0, 1);
        evt_setup_done_i = 1; tick();
        expect_now("R2", 8'h38, 8'h80, 0, 1);

        // R3: writing all ones keeps everything
        wr_flag(8'hFF);
        expect_now("R3", 8'h38, 8'h80, 0, 1);
        // R3: clear only bit 3
        wr_flag(8'hF7);
        expect_now("R3", 8'h30, 8'h80, 0, 1);
        // R3/R6/R10: write all zeros clears bit 5, bit 4 unaffected
        wr_flag(8'h00);
        expect_now("R6", 8'h10, 8'h80, 0, 0);

        // R4: set and clear on the same edge -> set wins
        evt_setup_done_i = 1; cpu_wr_flag_i = 1; cpu_wdata_i = 8'h00; tick();
        expect_now("R4", 8'h18, 8'h80, 0, 0);
        evt_tx_request_i = 1; cpu_wr_flag_i = 1; cpu_wdata_i = 8'hF7; tick();
        expect_now("R4", 8'h30, 8'h80, 0, 1);
        wr_flag(8'h00);
        expect_now("R3", 8'h10, 8'h80, 0, 0);

        // R5: receive-full mirrors with one cycle delay, not clearable
        rx_fifo_full_i = 1;
        expect_now("R5", 8'h10, 8'h80, 0, 0);
        tick();
        expect_now("R5", 8'h50, 8'h80, 0, 0);
        wr_flag(8'h00);
        expect_now("R5", 8'h50, 8'h80, 0, 0);
        rx_fifo_full_i = 0; tick();
        expect_now("R5", 8'h10, 8'h80, 0, 0);

        // R6: OR of the two transmit buffers, every combination
        tx_buf_free_i = 2'b01; tick();
        expect_now("R6", 8'h10, 8'h80, 0, 0);
        tx_buf_free_i = 2'b10; tick();
        expect_now("R6", 8'h10, 8'h80, 0, 0);
        tx_buf_free_i = 2'b00; tick();
        expect_now("R6", 8'h00, 8'h80, 0, 0);
        wr_flag(8'hFF);
        expect_now("R6", 8'h00, 8'h80, 0, 0);
        tx_buf_free_i = 2'b11; tick();
        expect_now("R6", 8'h10, 8'h80, 0, 0);

        // R7: reserved bits stay 0 even with all writable bits set
        evt_bus_reset_i = 1; evt_tx_request_i = 1; evt_setup_done_i = 1;
        rx_fifo_full_i = 1; tick();
        wr_flag(8'hFF);
        expect_now("R7", 8'hF8, 8'h80, 1, 1);
        wr_flag(8'h00);
        rx_fifo_full_i = 0; tick();
        expect_now("R7", 8'h10, 8'h80, 0, 0);

        // R8: enable stores all bits
        wr_en(8'hA5);
        expect_now("R8", 8'h10, 8'hA5, 0, 0);

        // R9: live bit 4 drives irq through its enable
        wr_en(8'h10);
        tick();
        expect_now("R9", 8'h10, 8'h10, 1, 0);
        tx_buf_free_i = 2'b00; tick();
        expect_now("R9", 8'h00, 8'h10, 1, 0);
        tick();
        expect_now("R9", 8'h00, 8'h10, 0, 0);

        // R1: reset mid-run restores the initial word
        evt_tx_request_i = 1; tick();
        rst_n = 0; tx_buf_free_i = 2'b11; tick();
        expect_now("R1", 8'h10, 8'h00, 0, 0);

        tick();
        wait (exp_q.size() == 0);
        #1;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule